// File: doc/BRIEF.md
# PSI5 Synchronous Slot Timing Controller

This block schedules one channel of a PSI5 master. It runs from a 4 MHz reference clock and produces three outputs. The first is a sync-pulse request strobe for the analog sync-voltage driver. The second is a set of receive-slot enables, one per sensor data slot. The third is an enable for the Manchester receive decoder that stays low during blanking intervals. All timing counts in clocks of that reference.

A host sync input controls when frames begin, and `mode_i` chooses how. In time-division mode, a host pulse of at least 40 µs starts a continuous schedule. That schedule issues a sync request every 500 µs and opens three abutting slot windows in each period. In externally steered mode, each rising edge of the host input starts exactly one frame. The sync request is delayed by a stagger of 16 clocks per channel index, so that neighbouring channels do not pulse together.

The decoder enable is held low in two cases: for the first 69 µs of every frame, and for 10 µs after every transition of the host input.

Top module: `psi5_slot_timer`

## Requirements
- R1: While `rst_ni` is low, `sync_req_o`, `slot_en_o` and `rx_en_o` are all 0. After reset they stay 0 until a frame starts.
- R2: With `mode_i`=0 (time-division), let P be the first clock edge that samples `host_sync_i` high. If the input then stays high for at least MIN_PULSE_CLKS (160) clock edges, a frame starts at P+1+MIN_PULSE_CLKS. The frame start is the first cycle with `sync_req_o` high.
- R3: In time-division mode, a host pulse sampled high on fewer than MIN_PULSE_CLKS edges (159 or fewer) starts nothing.
- R4: `sync_req_o` is high for the first SYNC_CLKS (128) cycles of each frame.
- R5: Counting from the frame start, slot 1 (`slot_en_o[0]`) covers cycles [176,725), slot 2 (`slot_en_o[1]`) covers [725,1316), and slot 3 (`slot_en_o[2]`) covers [1316,1968). At most one slot bit is high at a time.
- R6: In time-division mode, frames repeat every PERIOD_CLKS (2000) cycles. Host pulses that arrive while a frame runs do not restart the schedule.
- R7: `mode_i` is sampled only while idle and in the last cycle of a frame. A change to steered mode in the middle of a frame lets that frame finish, and then no further frame follows.
- R8: With `mode_i`=1 (steered), let P be the edge that first samples a rising `host_sync_i`. One frame starts at P+SAMPLE_STAGES+CH_IDX*STAGGER_STEP, which is P+2+16*CH_IDX. The block returns to idle when the frame ends.
- R9: In steered mode, host edges that arrive while a frame runs neither restart nor extend that frame.
- R10: `rx_en_o` is high only while a slot bit is high, and is low for the first SYNC_BLANK_CLKS (276) cycles of every frame.
- R11: Let P be the edge that first samples a new level of `host_sync_i`. `rx_en_o` is low for cycles [P+2, P+2+EDGE_BLANK_CLKS), with EDGE_BLANK_CLKS = 40.
- R12: Time-division frames carry no per-channel stagger, whatever CH_IDX is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (4 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = time-division schedule, 1 = externally steered |
| host_sync_i | input | 1 | Asynchronous host sync input |
| sync_req_o | output | 1 | Sync-pulse request strobe |
| slot_en_o | output | 3 | Receive-slot windows, bit 0 = slot 1 |
| rx_en_o | output | 1 | Receive-decoder enable with blanking applied |

## Verification
The bench keeps every timing parameter at its default, so each slot edge is checked at its exact 4 MHz clock count. The one exception is CH_IDX, which is set to 2. That gives a 32-clock stagger, so the steered frame start can be told apart from an unstaggered one. The same setting shows that time-division frames ignore the stagger. Host pulses of 159 and 160 sampled clocks bracket the acceptance threshold. Host pulses placed inside running frames cut visible holes in the decoder enable, and they also test that a busy channel cannot be restarted.

// File: rtl/psi5_slot_pkg.sv
package psi5_slot_pkg;
    localparam int NUM_SLOTS = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef enum logic {
        MODE_TDM   = 1'b0,
        MODE_STEER = 1'b1
    } mode_e;
endpackage

// File: rtl/psi5_host_sync_in.sv
// Synchronises the host sync input, flags its transitions and qualifies
// the width of a high pulse.
module psi5_host_sync_in #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 160
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic host_i,
    output logic toggle_o,
    output logic rise_o,
    output logic accept_o
);
    localparam int WID_W = $clog2(MIN_PULSE + 1);
    localparam logic [WID_W-1:0] WID_LAST = WID_W'(MIN_PULSE - 1);
    localparam logic [WID_W-1:0] WID_SAT  = WID_W'(MIN_PULSE);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic [WID_W-1:0]       width;
    } hs_t;

    hs_t  s_d, s_q;
    logic lvl;

    assign lvl = s_q.chain[SYNC_STAGES-1];

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], host_i};
        s_d.prev  = lvl;
        if (!lvl) begin
            s_d.width = '0;
        end else if (s_q.width != WID_SAT) begin
            s_d.width = s_q.width + WID_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign toggle_o = lvl ^ s_q.prev;
    assign rise_o   = lvl & ~s_q.prev;
    assign accept_o = lvl & (s_q.width == WID_LAST);
endmodule

// File: rtl/psi5_frame_timer.sv
// Frame sequencer: idle, optional stagger wait, then one frame of
// PERIOD_CLKS cycles. Time-division frames chain while the mode holds.
module psi5_frame_timer
    import psi5_slot_pkg::*;
#(
    parameter int PERIOD_CLKS  = 2000,
    parameter int STAGGER_CLKS = 0,
    parameter int CNT_W        = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic             accept_i,
    input  logic             rise_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(PERIOD_CLKS - 1);
    localparam logic [CNT_W-1:0] STG_LAST = CNT_W'(STAGGER_CLKS - 1);
    localparam phase_e STEER_ENTRY = (STAGGER_CLKS == 0) ? PH_RUN : PH_WAIT;

    typedef struct packed {
        phase_e           phase;
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
    } tm_t;

    tm_t   t_d, t_q;
    mode_e mode_in;

    assign mode_in = mode_e'(mode_i);

    always_comb begin
        t_d = t_q;
        case (t_q.phase)
            PH_IDLE: begin
                t_d.cnt = '0;
                if (mode_in == MODE_TDM && accept_i) begin
                    t_d.mode  = MODE_TDM;
                    t_d.phase = PH_RUN;
                end else if (mode_in == MODE_STEER && rise_i) begin
                    t_d.mode  = MODE_STEER;
                    t_d.phase = STEER_ENTRY;
                end
            end
            PH_WAIT: begin
                if (t_q.cnt == STG_LAST) begin
                    t_d.cnt   = '0;
                    t_d.phase = PH_RUN;
                end else begin
                    t_d.cnt = t_q.cnt + CNT_W'(1);
                end
            end
            PH_RUN: begin
                if (t_q.cnt == PER_LAST) begin
                    t_d.cnt = '0;
                    if (!(t_q.mode == MODE_TDM && mode_in == MODE_TDM)) begin
                        t_d.phase = PH_IDLE;
                    end
                end else begin
                    t_d.cnt = t_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                t_d.phase = PH_IDLE;
                t_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign run_o = (t_q.phase == PH_RUN);
    assign cnt_o = t_q.cnt;
endmodule

// File: rtl/psi5_window_decode.sv
// Decodes the frame count into sync request and slot windows, and gates
// the decoder enable with sync blanking and host-edge blanking.
module psi5_window_decode
    import psi5_slot_pkg::*;
#(
    parameter int CNT_W           = 11,
    parameter int SYNC_CLKS       = 128,
    parameter int SLOT1_CLK       = 176,
    parameter int SLOT2_CLK       = 725,
    parameter int SLOT3_CLK       = 1316,
    parameter int SLOT_END_CLK    = 1968,
    parameter int SYNC_BLANK_CLKS = 276,
    parameter int EDGE_BLANK_CLKS = 40
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic                 toggle_i,
    output logic                 sync_req_o,
    output logic [NUM_SLOTS-1:0] slot_en_o,
    output logic                 rx_en_o
);
    localparam int EB_W = $clog2(EDGE_BLANK_CLKS + 1);
    localparam int SLOT_LO [NUM_SLOTS] = '{SLOT1_CLK, SLOT2_CLK, SLOT3_CLK};
    localparam int SLOT_HI [NUM_SLOTS] = '{SLOT2_CLK, SLOT3_CLK, SLOT_END_CLK};

    typedef struct packed {
        logic [EB_W-1:0] edge_left;
    } bl_t;

    bl_t  b_d, b_q;
    logic sync_blank;
    logic edge_blank;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_en_o[g] = run_i
                            && (cnt_i >= CNT_W'(SLOT_LO[g]))
                            && (cnt_i <  CNT_W'(SLOT_HI[g]));
    end

    always_comb begin
        b_d = b_q;
        if (toggle_i) begin
            b_d.edge_left = EB_W'(EDGE_BLANK_CLKS);
        end else if (b_q.edge_left != '0) begin
            b_d.edge_left = b_q.edge_left - EB_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= '0;
        else         b_q <= b_d;
    end

    assign sync_req_o = run_i && (cnt_i < CNT_W'(SYNC_CLKS));
    assign sync_blank = cnt_i < CNT_W'(SYNC_BLANK_CLKS);
    assign edge_blank = (b_q.edge_left != '0);
    assign rx_en_o    = (|slot_en_o) && !sync_blank && !edge_blank;
endmodule

// File: rtl/psi5_slot_timer.sv
// One PSI5 master channel: sync request, slot windows, decoder enable.
module psi5_slot_timer
    import psi5_slot_pkg::*;
#(
    parameter int PERIOD_CLKS     = 2000,
    parameter int SYNC_CLKS       = 128,
    parameter int SLOT1_CLK       = 176,
    parameter int SLOT2_CLK       = 725,
    parameter int SLOT3_CLK       = 1316,
    parameter int SLOT_END_CLK    = 1968,
    parameter int SYNC_BLANK_CLKS = 276,
    parameter int EDGE_BLANK_CLKS = 40,
    parameter int MIN_PULSE_CLKS  = 160,
    parameter int SAMPLE_STAGES   = 2,
    parameter int STAGGER_STEP    = 16,
    parameter int CH_IDX          = 0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 mode_i,
    input  logic                 host_sync_i,
    output logic                 sync_req_o,
    output logic [NUM_SLOTS-1:0] slot_en_o,
    output logic                 rx_en_o
);
    localparam int STAGGER_CLKS = CH_IDX * STAGGER_STEP;
    localparam int CNT_SPAN     = (PERIOD_CLKS > STAGGER_CLKS) ? PERIOD_CLKS : STAGGER_CLKS + 1;
    localparam int CNT_W        = $clog2(CNT_SPAN);

    logic             toggle;
    logic             rise;
    logic             accept;
    logic             run;
    logic [CNT_W-1:0] cnt;

    psi5_host_sync_in #(
        .SYNC_STAGES (SAMPLE_STAGES),
        .MIN_PULSE   (MIN_PULSE_CLKS)
    ) u_host (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .host_i   (host_sync_i),
        .toggle_o (toggle),
        .rise_o   (rise),
        .accept_o (accept)
    );

    psi5_frame_timer #(
        .PERIOD_CLKS  (PERIOD_CLKS),
        .STAGGER_CLKS (STAGGER_CLKS),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode_i),
        .accept_i (accept),
        .rise_i   (rise),
        .run_o    (run),
        .cnt_o    (cnt)
    );

    psi5_window_decode #(
        .CNT_W           (CNT_W),
        .SYNC_CLKS       (SYNC_CLKS),
        .SLOT1_CLK       (SLOT1_CLK),
        .SLOT2_CLK       (SLOT2_CLK),
        .SLOT3_CLK       (SLOT3_CLK),
        .SLOT_END_CLK    (SLOT_END_CLK),
        .SYNC_BLANK_CLKS (SYNC_BLANK_CLKS),
        .EDGE_BLANK_CLKS (EDGE_BLANK_CLKS)
    ) u_win (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .cnt_i      (cnt),
        .toggle_i   (toggle),
        .sync_req_o (sync_req_o),
        .slot_en_o  (slot_en_o),
        .rx_en_o    (rx_en_o)
    );
endmodule

// File: rtl/psi5_slot_timer_chk.sv
module psi5_slot_timer_chk
    import psi5_slot_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 sync_req_o,
    input logic [NUM_SLOTS-1:0] slot_en_o,
    input logic                 rx_en_o
);
    AST_SLOTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(slot_en_o)); // R5
    AST_SLOT2_AFTER_SLOT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(slot_en_o[1]) |-> $past(slot_en_o[0])); // R5
    AST_SLOT3_AFTER_SLOT2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(slot_en_o[2]) |-> $past(slot_en_o[1])); // R5
    AST_NO_SLOT_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_req_o |-> (slot_en_o == '0)); // R4
    AST_RX_ONLY_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_en_o |-> (|slot_en_o)); // R10
    AST_RX_QUIET_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sync_req_o) |-> !rx_en_o); // R10
endmodule

bind psi5_slot_timer psi5_slot_timer_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_req_o (sync_req_o),
    .slot_en_o  (slot_en_o),
    .rx_en_o    (rx_en_o)
);

// File: tb/psi5_slot_timer_tb.sv
module psi5_slot_timer_tb;
    localparam int WDOG = 20000;

    typedef struct {
        int    v;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       host = 1'b0;
    logic       sync_req;
    logic [2:0] slot_en;
    logic       rx_en;

    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    int   n_sync_rise = 0;
    int   last_sync_rise = -100000;
    int   blank_viol = 0;
    logic [4:0] prev_obs = '0;
    exp_t exp_q [5][$];

    always #4 clk = ~clk;

    psi5_slot_timer #(.CH_IDX(2)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mode_i      (mode),
        .host_sync_i (host),
        .sync_req_o  (sync_req),
        .slot_en_o   (slot_en),
        .rx_en_o     (rx_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle*2+level)", req, act, expv);
        end
    endtask

    task automatic push(input int s, input int c, input int lvl, input string req);
        exp_t e;
        e.v   = c * 2 + lvl;
        e.req = req;
        exp_q[s].push_back(e);
    endtask

    task automatic push_frame(input int s, input string start_req);
        push(0, s, 1, start_req);
        push(0, s + 128, 0, "R4");
        push(1, s + 176, 1, "R5");
        push(1, s + 725, 0, "R5");
        push(2, s + 725, 1, "R5");
        push(2, s + 1316, 0, "R5");
        push(3, s + 1316, 1, "R5");
        push(3, s + 1968, 0, "R5");
    endtask

    task automatic at_cyc(input int n);
        @(negedge clk);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compares every output transition against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] obs;
            obs = {rx_en, slot_en, sync_req};
            for (int i = 0; i < 5; i++) begin
                if (obs[i] !== prev_obs[i]) begin
                    int got;
                    got = cyc * 2 + int'(obs[i]);
                    if (exp_q[i].size() == 0) begin
                        check(1'b0, (i == 4) ? "R10 unexpected" : "R5 unexpected", got, -1);
                    end else begin
                        exp_t e;
                        e = exp_q[i].pop_front();
                        check(got == e.v, e.req, got, e.v);
                    end
                end
            end
            if (obs[0] && !prev_obs[0]) begin
                n_sync_rise++;
                last_sync_rise = cyc;
            end
            if (rx_en && (cyc - last_sync_rise < 276)) blank_viol++;
            prev_obs = obs;
        end
    end

    always @(posedge clk) begin
        if (cyc == WDOG) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int r;
        int rs;
        // R1: reset state
        at_cyc(3);
        check({sync_req, slot_en, rx_en} == 5'b0, "R1", int'({sync_req, slot_en, rx_en}), 0);
        at_cyc(5);
        rst_n = 1'b1;

        // R3: 159-clock pulse in time-division mode is rejected
        at_cyc(20);
        host = 1'b1;
        at_cyc(179);
        host = 1'b0;
        at_cyc(390);
        check(n_sync_rise == 0, "R3", n_sync_rise, 0);
        check({sync_req, slot_en, rx_en} == 5'b0, "R1", int'({sync_req, slot_en, rx_en}), 0);

        // R2, R12: 160-clock pulse starts the schedule without stagger
        r = 562;
        push_frame(r, "R2");
        push(4, r + 276, 1, "R10");
        push(4, r + 1503, 0, "R11");
        push(4, r + 1543, 1, "R11");
        push(4, r + 1703, 0, "R11");
        push(4, r + 1743, 1, "R11");
        push(4, r + 1968, 0, "R10");
        push_frame(r + 2000, "R6");
        push(4, r + 2276, 1, "R10");
        push(4, r + 3968, 0, "R10");
        at_cyc(400);
        host = 1'b1;
        at_cyc(560);
        host = 1'b0;
        at_cyc(r + 10);
        check(sync_req === 1'b1, "R12", int'(sync_req), 1);

        // R6: long host pulse inside a running frame does not restart it
        at_cyc(r + 1500);
        host = 1'b1;
        at_cyc(r + 1700);
        host = 1'b0;

        // R7: switch to steered mode mid-frame; frame finishes, then stop
        at_cyc(r + 2500);
        mode = 1'b1;
        at_cyc(r + 4500);
        check(n_sync_rise == 2, "R7", n_sync_rise, 2);
        check(slot_en == 3'b0, "R7", int'(slot_en), 0);

        // R8, R9, R11: steered frame with stagger 32 and a mid-frame pulse
        rs = r + 4600 + 35;
        push_frame(rs, "R8");
        push(4, rs + 276, 1, "R10");
        push(4, rs + 903, 0, "R11");
        push(4, rs + 943, 1, "R11");
        push(4, rs + 1003, 0, "R11");
        push(4, rs + 1043, 1, "R11");
        push(4, rs + 1968, 0, "R10");
        at_cyc(r + 4600);
        host = 1'b1;
        at_cyc(r + 4800);
        host = 1'b0;
        at_cyc(rs + 900);
        host = 1'b1;
        at_cyc(rs + 1000);
        host = 1'b0;
        at_cyc(rs + 2300);
        check(n_sync_rise == 3, "R9", n_sync_rise, 3);
        check(sync_req === 1'b0, "R8", int'(sync_req), 0);

        check(blank_viol == 0, "R10", blank_viol, 0);
        for (int i = 0; i < 5; i++) begin
            check(exp_q[i].size() == 0, "R5 missing", exp_q[i].size(), 0);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule